// File: doc/BRIEF.md
# Four-Function Byte ALU with Carry and Overflow Flags

This block is a purely combinational arithmetic/logic unit for two unsigned 8-bit operands. A 2-bit operation code picks one of four functions: sum, difference (second operand taken from the first), bitwise AND, or bitwise OR. The 8-bit result appears on one output bus. Two flag outputs accompany it: a carry/borrow bit and a two's-complement overflow bit.

Carry and borrow come from one 9-bit adder/subtractor. Both operands are widened with a leading zero, and the ninth bit of the 9-bit outcome is the flag. The overflow flag reads the same operands as signed values. The logic functions leave both flags at zero. The block holds no state: outputs follow the inputs in the same cycle, and any registering is left to the surrounding logic.

Top module: `quad_op_alu`

## Requirements
- R1: With op_sel = 2'b00 the result equals (A + B) modulo 256.
- R2: With op_sel = 2'b00 the carry flag is 1 exactly when A + B exceeds 255.
- R3: With op_sel = 2'b01 the result equals (A - B) modulo 256.
- R4: With op_sel = 2'b01 the carry flag acts as a borrow and is 1 exactly when A < B as unsigned numbers.
- R5: With op_sel = 2'b10 every result bit is the AND of the matching operand bits.
- R6: With op_sel = 2'b11 every result bit is the OR of the matching operand bits.
- R7: With op_sel = 2'b00 the overflow flag is 1 exactly when A and B have the same bit 7 and the result's bit 7 differs from it.
- R8: With op_sel = 2'b01 the overflow flag is 1 exactly when A and B differ in bit 7 and the result's bit 7 differs from A's bit 7.
- R9: With op_sel = 2'b10 or 2'b11 both the carry flag and the overflow flag are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand (A), unsigned |
| opnd_b | input | 8 | Second operand (B), unsigned |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Carry for add, borrow for subtract, 0 otherwise |
| ovf_out | output | 1 | Signed overflow for add and subtract, 0 otherwise |

## Verification
Every operation is driven with each pairing of 0x00, 0x01, 0x7F, 0x80 and 0xFF. Pairs of 0x7F and 0x80 sit on the signed boundary and tell the two overflow rules apart from the carry rule. 0xFF pairs make the carry wrap, and equal operands give a zero difference with no borrow. 0x00 and 0xFF also show whether each logic bit is ANDed or ORed. More than a thousand random operand pairs under random operation codes cover the general case against an integer reference model.

// File: rtl/quad_alu_pkg.sv
// Package: shared operation encoding for the four-function ALU.
// Assumes: a 2-bit operation field; callers cast their raw select into alu_op_e.
package quad_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// Adds or subtracts two unsigned W-bit operands. Both are widened by one zero
// bit, and the extra bit of the wide result gives the carry (add) or borrow (sub).
// Signed overflow is derived from the operand and result sign bits.
// Assumes: W >= 2; purely combinational.
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         do_sub,
    output logic [W-1:0] sum_out,
    output logic         cb_out,
    output logic         ovf_out
);

    localparam int EW  = W + 1;
    localparam int MSB = W - 1;

    logic [EW-1:0] ext_a;
    logic [EW-1:0] ext_b;
    logic [EW-1:0] wide;

    // Widen both operands with a leading zero and form the wide sum or difference.
    always_comb begin
        ext_a = {1'b0, a_in};
        ext_b = {1'b0, b_in};
        wide  = do_sub ? (ext_a - ext_b) : (ext_a + ext_b);
    end

    assign sum_out = wide[W-1:0];
    assign cb_out  = wide[W];

    // Signed overflow: the sign rule depends on the direction of the operation.
    always_comb begin
        if (do_sub)
            ovf_out = (a_in[MSB] ^ b_in[MSB]) & (sum_out[MSB] ^ a_in[MSB]);
        else
            ovf_out = ~(a_in[MSB] ^ b_in[MSB]) & (sum_out[MSB] ^ a_in[MSB]);
    end

endmodule

// File: rtl/alu_bitwise.sv
// Module: alu_bitwise
// Forms a bit-by-bit AND or OR of two W-bit operands, one slice per bit.
// Assumes: purely combinational; use_or = 1 selects OR, else AND.
module alu_bitwise #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         use_or,
    output logic [W-1:0] y_out
);

    // One slice per bit position, each picking AND or OR.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_out[i] = use_or ? (a_in[i] | b_in[i]) : (a_in[i] & b_in[i]);
    end

endmodule

// File: rtl/quad_op_alu.sv
// Module: quad_op_alu (top)
// Four-function combinational ALU: add, subtract, AND, OR on two unsigned
// bytes, with carry/borrow and signed overflow flags. Flags are zero for the
// logic functions.
// Assumes: no clock or reset inside; outputs follow inputs in the same cycle.
module quad_op_alu
    import quad_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf_out
);

    alu_op_e      op;
    logic [W-1:0] arith_y;
    logic         arith_cb;
    logic         arith_ovf;
    logic [W-1:0] logic_y;

    assign op = alu_op_e'(op_sel);

    alu_addsub #(.W(W)) u_arith (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .do_sub  (op == OP_SUB),
        .sum_out (arith_y),
        .cb_out  (arith_cb),
        .ovf_out (arith_ovf)
    );

    alu_bitwise #(.W(W)) u_logic (
        .a_in   (opnd_a),
        .b_in   (opnd_b),
        .use_or (op == OP_OR),
        .y_out  (logic_y)
    );

    // Route the selected unit to the outputs; flags only for arithmetic.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB: begin
                result    = arith_y;
                carry_out = arith_cb;
                ovf_out   = arith_ovf;
            end
            default: begin
                result    = logic_y;
                carry_out = 1'b0;
                ovf_out   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/quad_op_alu_chk.sv
// Module: quad_op_alu_chk
// Checker for quad_op_alu: relates the outputs to the operands for each
// operation code (00 add, 01 sub, 10 AND, 11 OR). Attached by bind below.
// Assumes: the checked block is combinational, so immediate checks are used.
module quad_op_alu_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [1:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         ovf_out
);

    localparam int MSB = W - 1;

    // Check each output against its operation's defining relation.
    always_comb begin
        if (op_sel == 2'b00) begin
            AST_ADD_RESULT: assert (W'(result - opnd_a) == opnd_b) else $error("add result"); // R1
            AST_ADD_CARRY: assert (carry_out == (result < opnd_a)) else $error("add carry"); // R2
            AST_ADD_OVF: assert (ovf_out == ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]))) else $error("add ovf"); // R7
        end
        if (op_sel == 2'b01) begin
            AST_SUB_RESULT: assert (W'(result + opnd_b) == opnd_a) else $error("sub result"); // R3
            AST_SUB_BORROW: assert (carry_out == (opnd_a < opnd_b)) else $error("sub borrow"); // R4
            AST_SUB_OVF: assert (ovf_out == ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]))) else $error("sub ovf"); // R8
        end
        if (op_sel == 2'b10) begin
            AST_AND_BITS: assert (((result & ~opnd_a) == '0) && ((result & ~opnd_b) == '0) && ((opnd_a & opnd_b & ~result) == '0)) else $error("and"); // R5
        end
        if (op_sel == 2'b11) begin
            AST_OR_BITS: assert (((result & ~(opnd_a | opnd_b)) == '0) && (((opnd_a | opnd_b) & ~result) == '0)) else $error("or"); // R6
        end
        if (op_sel[1]) begin
            AST_NO_FLAGS: assert (!carry_out && !ovf_out) else $error("logic flags"); // R9
        end
    end

endmodule

bind quad_op_alu quad_op_alu_chk #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .ovf_out   (ovf_out)
);

// File: tb/sim_quad_op_alu.sv
// Bench for quad_op_alu: integer reference model, corner pairs and random vectors.
module sim_quad_op_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] result;
    logic       carry_out;
    logic       ovf_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  cycles   = 0;
    bit  reported = 1'b0;

    always #5 clk = ~clk;

    quad_op_alu u0 (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_sel    (op_sel),
        .result    (result),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    // Print the summary once and stop.
    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Compare one value and report a mismatch.
    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h op=%0d)",
                     tag, act, exp, opnd_a, opnd_b, op_sel);
        end
    endtask

    function automatic int to_signed(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Drive one vector after a clock edge and check it before the next edge.
    task automatic run_vec(input int a, input int b, input int op);
        int exp_r, exp_c, exp_v, sa, sb, full;
        string tr, tc, tv;
        @(posedge clk);
        #1;
        opnd_a = 8'(a);
        opnd_b = 8'(b);
        op_sel = 2'(op);
        sa = to_signed(a);
        sb = to_signed(b);
        case (op)
            0: begin
                full  = a + b;
                exp_r = full % 256;
                exp_c = (full > 255) ? 1 : 0;
                exp_v = ((sa + sb) > 127 || (sa + sb) < -128) ? 1 : 0;
                tr = "R1"; tc = "R2"; tv = "R7";
            end
            1: begin
                full  = a - b;
                exp_r = (full + 256) % 256;
                exp_c = (a < b) ? 1 : 0;
                exp_v = ((sa - sb) > 127 || (sa - sb) < -128) ? 1 : 0;
                tr = "R3"; tc = "R4"; tv = "R8";
            end
            2: begin
                exp_r = 0;
                for (int i = 0; i < 8; i++)
                    if (((a >> i) & 1) == 1 && ((b >> i) & 1) == 1) exp_r += (1 << i);
                exp_c = 0; exp_v = 0;
                tr = "R5"; tc = "R9"; tv = "R9";
            end
            default: begin
                exp_r = 0;
                for (int i = 0; i < 8; i++)
                    if (((a >> i) & 1) == 1 || ((b >> i) & 1) == 1) exp_r += (1 << i);
                exp_c = 0; exp_v = 0;
                tr = "R6"; tc = "R9"; tv = "R9";
            end
        endcase
        #3;
        check(tr, int'(result), exp_r);
        check(tc, int'(carry_out), exp_c);
        check(tv, int'(ovf_out), exp_v);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        int corner [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        // Reset-time state: zero operands, add, all outputs zero (R1, R2, R7).
        repeat (3) @(posedge clk);
        #2;
        check("R1", int'(result), 0);
        check("R2", int'(carry_out), 0);
        check("R7", int'(ovf_out), 0);
        rst_n = 1'b1;
        // Corner pairs, including equal operands, for every operation.
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    run_vec(corner[i], corner[j], op);
        // Random vectors.
        for (int k = 0; k < 1200; k++)
            run_vec(int'($urandom_range(255)), int'($urandom_range(255)), int'($urandom_range(3)));
        finish_run();
    end

endmodule